// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block decides which of a CAN controller's transmit mailboxes goes to the bus next. Software marks mailboxes as waiting by writing 1s to a request vector. The block then runs an internal contest among all waiting mailboxes. The one carrying the numerically smallest identifier wins, and on equal identifiers the lower mailbox number wins. The winning mailbox number and its identifier are handed to a bus engine through a simple request/result handshake. The bus engine handles framing, stuffing, CRC and the wire itself.

The engine answers with a done strobe and one of three result codes:

- success,
- lost arbitration,
- transmission error.

On success the mailbox leaves the waiting set and its acknowledge flag is raised. On the other two results the mailbox stays waiting and a fresh contest is run, so retries happen without software. A newer, more urgent mailbox can therefore overtake a retry.

Software can withdraw a waiting mailbox through a cancel vector. A cancel is held back while that mailbox is in the internal contest or on the bus. A held-back cancel is applied once the mailbox leaves that phase, unless its transmission succeeded, in which case the cancel is dropped. Acknowledge and abort flags drive one interrupt line through per-mailbox masks and a global enable.

Top module: `can_txmb_sched`

## Requirements
- R1: After reset, `pending`, `tx_ack` and `abort_ack` are all zero, and `bus_req` and `irq` are low.
- R2: Bit k of every per-mailbox vector belongs to mailbox k+1. Writing 1 to bit k of `tx_req` makes mailbox k+1 waiting. The next bus request carries the waiting mailbox with the smallest identifier; ties go to the smaller mailbox number. `bus_idx` gives the mailbox number (1 to 15) and `bus_id` gives its identifier.
- R3: The identifier of mailbox k+1 is bits [k*ID_W +: ID_W] of `mb_id`.
- R4: When `bus_done` arrives with `bus_result` = 0 (success), the mailbox's `pending` bit clears and its `tx_ack` bit sets on that clock edge.
- R5: When `bus_done` arrives with `bus_result` = 1 (lost arbitration) or 2 (error), the mailbox stays pending and is requested on the bus again without any software write.
- R6: After any bus result, the next mailbox is chosen afresh among all waiting mailboxes. A higher-priority mailbox made waiting during the failed attempt is sent before the retry.
- R7: A cancel (write 1 to `cancel_req`) on a waiting mailbox that is neither in the contest nor on the bus clears its `pending` bit and sets its `abort_ack` bit on that edge.
- R8: A cancel on the mailbox currently on the bus leaves it pending and leaves `bus_req` high. The cancel is applied after a failed attempt: `pending` clears, `abort_ack` sets, and no further bus request is made for that mailbox.
- R9: A held-back cancel whose transmission then succeeds is dropped: `tx_ack` sets and `abort_ack` stays clear.
- R10: `irq` is high exactly when `empty_irq_en` is 1 and some mailbox has its `irq_mask` bit at 1 together with its `tx_ack` or `abort_ack` bit set.
- R11: Writing 1 to a bit of `ack_clr` or `abort_clr` clears the matching `tx_ack` or `abort_ack` bit.
- R12: While `bus_req` is high and `bus_done` is low, `bus_req` stays high and `bus_idx` does not change on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_req | input | NUM_MB | Write-1 pulses that make mailboxes waiting |
| cancel_req | input | NUM_MB | Write-1 pulses that request cancellation |
| ack_clr | input | NUM_MB | Write-1 pulses that clear acknowledge flags |
| abort_clr | input | NUM_MB | Write-1 pulses that clear abort flags |
| mb_id | input | NUM_MB*ID_W | Packed identifiers, mailbox k+1 at slice k |
| irq_mask | input | NUM_MB | Per-mailbox interrupt enable (1 = enabled) |
| empty_irq_en | input | 1 | Global mailbox-empty interrupt enable |
| bus_req | output | 1 | Transmit buffer loaded, bus attempt requested |
| bus_idx | output | IDX_W | Mailbox number (1..NUM_MB) in the buffer |
| bus_id | output | ID_W | Identifier of the buffered message |
| bus_done | input | 1 | Bus engine result strobe |
| bus_result | input | 2 | 0 success, 1 lost arbitration, 2 error |
| pending | output | NUM_MB | Waiting-for-transmission flags |
| tx_ack | output | NUM_MB | Successful-transmission flags |
| abort_ack | output | NUM_MB | Cancelled flags |
| irq | output | 1 | Mailbox-empty interrupt |

## Verification
Priority selection is tried with three mailboxes waiting at once. Two of them share an identifier and one has a larger identifier, so the run separates ordering by identifier from ordering by mailbox number. Retries are driven with an error result and with a lost-arbitration result. In the lost-arbitration case an urgent mailbox is raised mid-attempt, which separates "re-contest after a result" from "repeat the same mailbox". Cancels are issued in three situations: on an idle waiting mailbox, on the mailbox in flight followed by a failure, and on the mailbox in flight followed by a success. Together these separate immediate, deferred and dropped cancellation. The interrupt is checked under each combination of mask and global enable.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_BUS  = 2'd2
    } sched_st_e;

    localparam logic [1:0] RES_OK   = 2'd0;
    localparam logic [1:0] RES_LOST = 2'd1;
    localparam logic [1:0] RES_ERR  = 2'd2;
endpackage

// File: rtl/can_txmb_pick.sv
module can_txmb_pick #(
    parameter int NUM_MB = 15,
    parameter int ID_W   = 11,
    parameter int IDX_W  = 4
) (
    input  logic [NUM_MB-1:0]      cand,
    input  logic [NUM_MB*ID_W-1:0] ids,
    output logic                   found,
    output logic [IDX_W-1:0]       win
);
    logic [ID_W-1:0] best;

    // strict compare keeps the lower index on equal identifiers
    always_comb begin
        found = 1'b0;
        win   = '0;
        best  = '1;
        for (int i = 0; i < NUM_MB; i++) begin
            if (cand[i] && (!found || ids[i*ID_W +: ID_W] < best)) begin
                found = 1'b1;
                best  = ids[i*ID_W +: ID_W];
                win   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (found) assert (cand[win]) else $error("p_pick_valid_r2");
    end
endmodule

// File: rtl/can_txmb_irq.sv
module can_txmb_irq #(
    parameter int NUM_MB = 15
) (
    input  logic [NUM_MB-1:0] ack,
    input  logic [NUM_MB-1:0] abort,
    input  logic [NUM_MB-1:0] mask,
    input  logic              en,
    output logic              irq
);
    always_comb irq = en & (|((ack | abort) & mask));
endmodule

// File: rtl/can_txmb_sched.sv
module can_txmb_sched
    import can_txmb_pkg::*;
#(
    parameter int NUM_MB = 15,
    parameter int ID_W   = 11,
    localparam int IDX_W = $clog2(NUM_MB + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MB-1:0]      tx_req,
    input  logic [NUM_MB-1:0]      cancel_req,
    input  logic [NUM_MB-1:0]      ack_clr,
    input  logic [NUM_MB-1:0]      abort_clr,
    input  logic [NUM_MB*ID_W-1:0] mb_id,
    input  logic [NUM_MB-1:0]      irq_mask,
    input  logic                   empty_irq_en,
    output logic                   bus_req,
    output logic [IDX_W-1:0]       bus_idx,
    output logic [ID_W-1:0]        bus_id,
    input  logic                   bus_done,
    input  logic [1:0]             bus_result,
    output logic [NUM_MB-1:0]      pending,
    output logic [NUM_MB-1:0]      tx_ack,
    output logic [NUM_MB-1:0]      abort_ack,
    output logic                   irq
);
    localparam logic [NUM_MB-1:0] ONE_MB  = {{(NUM_MB-1){1'b0}}, 1'b1};
    localparam logic [IDX_W-1:0]  ONE_IDX = {{(IDX_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        sched_st_e         st;
        logic [IDX_W-1:0]  sel;
        logic [NUM_MB-1:0] pend;
        logic [NUM_MB-1:0] ack;
        logic [NUM_MB-1:0] abort;
        logic [NUM_MB-1:0] canc;
    } regs_t;

    regs_t r_q, r_d;

    logic              pick_found;
    logic [IDX_W-1:0]  pick_win;
    logic [NUM_MB-1:0] sel_mask, prot, canc_all, cancel_eff, succ;

    can_txmb_pick #(.NUM_MB(NUM_MB), .ID_W(ID_W), .IDX_W(IDX_W)) u_pick (
        .cand  (r_q.pend),
        .ids   (mb_id),
        .found (pick_found),
        .win   (pick_win)
    );

    can_txmb_irq #(.NUM_MB(NUM_MB)) u_irq (
        .ack   (r_q.ack),
        .abort (r_q.abort),
        .mask  (irq_mask),
        .en    (empty_irq_en),
        .irq   (irq)
    );

    always_comb begin
        r_d      = r_q;
        sel_mask = ONE_MB << r_q.sel;
        // during the contest every waiting mailbox is protected
        case (r_q.st)
            ST_ARB:  prot = r_q.pend;
            ST_BUS:  prot = sel_mask;
            default: prot = '0;
        endcase
        canc_all   = r_q.canc | cancel_req;
        cancel_eff = canc_all & r_q.pend & ~prot;
        succ       = (r_q.st == ST_BUS && bus_done && bus_result == RES_OK) ? sel_mask : '0;

        r_d.pend  = (r_q.pend | tx_req) & ~cancel_eff & ~succ;
        r_d.canc  = canc_all & ~cancel_eff & ~succ & (r_q.pend | tx_req);
        r_d.ack   = (r_q.ack & ~ack_clr) | succ;
        r_d.abort = (r_q.abort & ~abort_clr) | cancel_eff;

        case (r_q.st)
            ST_IDLE: if (|r_q.pend) r_d.st = ST_ARB;
            ST_ARB: begin
                if (pick_found) begin
                    r_d.sel = pick_win;
                    r_d.st  = ST_BUS;
                end else begin
                    r_d.st  = ST_IDLE;
                end
            end
            ST_BUS:  if (bus_done) r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, sel: '0, pend: '0, ack: '0, abort: '0, canc: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_req   = (r_q.st == ST_BUS);
    assign bus_idx   = r_q.sel + ONE_IDX;
    assign bus_id    = mb_id[int'(r_q.sel)*ID_W +: ID_W];
    assign pending   = r_q.pend;
    assign tx_ack    = r_q.ack;
    assign abort_ack = r_q.abort;

    p_bus_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_done |=> bus_req && $stable(bus_idx));

    p_success_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_done && bus_result == RES_OK |=> tx_ack[$past(r_q.sel)]);

    p_retry_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_done && bus_result != RES_OK |=> pending[$past(r_q.sel)]);

    p_no_cancel_in_flight_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_done |=> pending[$past(r_q.sel)]);

    p_abort_from_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((abort_ack & ~$past(abort_ack) & ~$past(pending)) == '0));

    p_ack_from_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_ack & ~$past(tx_ack)) != '0) |-> $past(bus_req) && $past(bus_done));
endmodule

// File: tb/can_txmb_sched_test.sv
module can_txmb_sched_test;
    localparam int N  = 15;
    localparam int IW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  tx_req = '0, cancel_req = '0, ack_clr = '0, abort_clr = '0;
    logic [N*IW-1:0] mb_id = '1;
    logic [N-1:0]  irq_mask = '0;
    logic          empty_irq_en = 1'b0;
    logic          bus_done = 1'b0;
    logic [1:0]    bus_result = 2'd0;
    logic          bus_req, irq;
    logic [3:0]    bus_idx;
    logic [IW-1:0] bus_id;
    logic [N-1:0]  pending, tx_ack, abort_ack;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    can_txmb_sched uut (
        .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .cancel_req(cancel_req),
        .ack_clr(ack_clr), .abort_clr(abort_clr), .mb_id(mb_id),
        .irq_mask(irq_mask), .empty_irq_en(empty_irq_en),
        .bus_req(bus_req), .bus_idx(bus_idx), .bus_id(bus_id),
        .bus_done(bus_done), .bus_result(bus_result),
        .pending(pending), .tx_ack(tx_ack), .abort_ack(abort_ack), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic set_id(int mb, logic [IW-1:0] id);
        mb_id[(mb-1)*IW +: IW] = id;
    endtask

    task automatic req_tx(logic [N-1:0] v);
        @(negedge clk); tx_req = v;
        @(negedge clk); tx_req = '0;
    endtask

    task automatic req_cancel(logic [N-1:0] v);
        @(negedge clk); cancel_req = v;
        @(negedge clk); cancel_req = '0;
    endtask

    task automatic wait_bus(string req, int exp_mb);
        int k = 0;
        while (!bus_req && k < 20) begin
            @(negedge clk); k++;
        end
        check(req, {31'd0, bus_req}, 32'd1);
        check(req, 32'(bus_idx), 32'(exp_mb));
        check(req, 32'(bus_id), 32'(mb_id[(exp_mb-1)*IW +: IW]));
    endtask

    task automatic respond(logic [1:0] res);
        @(negedge clk); bus_done = 1'b1; bus_result = res;
        @(negedge clk); bus_done = 1'b0; bus_result = 2'd0;
    endtask

    task automatic clear_flags();
        @(negedge clk); ack_clr = '1; abort_clr = '1;
        @(negedge clk); ack_clr = '0; abort_clr = '0;
    endtask

    task automatic t_reset();
        check("R1 pending", 32'(pending), 0);
        check("R1 tx_ack", 32'(tx_ack), 0);
        check("R1 abort_ack", 32'(abort_ack), 0);
        check("R1 bus_req", {31'd0, bus_req}, 0);
        check("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_priority();
        set_id(3, 11'h100); set_id(5, 11'h050); set_id(7, 11'h050);
        req_tx(15'b000_0000_0101_0100);
        wait_bus("R2 R3 first winner", 5);
        respond(2'd0);
        check("R4 ack set", {31'd0, tx_ack[4]}, 1);
        check("R4 pending cleared", {31'd0, pending[4]}, 0);
        wait_bus("R2 tie then id order", 7);
        respond(2'd0);
        wait_bus("R2 largest id last", 3);
        respond(2'd0);
        check("R4 all done", 32'(pending), 0);
        check("R4 acks", 32'(tx_ack), 32'h0054);
        clear_flags();
    endtask

    task automatic t_retry();
        set_id(9, 11'h010);
        req_tx(15'b000_0000_0000_0100);
        wait_bus("R5 initial", 3);
        respond(2'd2);
        check("R5 pending kept after error", {31'd0, pending[2]}, 1);
        check("R5 no ack after error", {31'd0, tx_ack[2]}, 0);
        wait_bus("R5 retry after error", 3);
        req_tx(15'b000_0001_0000_0000);
        respond(2'd1);
        wait_bus("R6 urgent overtakes retry", 9);
        respond(2'd0);
        wait_bus("R5 retry after lost", 3);
        respond(2'd0);
        check("R5 R6 acks", 32'(tx_ack), 32'h0104);
        clear_flags();
    endtask

    task automatic t_cancel_idle();
        set_id(12, 11'h300);
        req_tx(15'b000_1000_0000_0100);
        wait_bus("R7 mb3 on bus", 3);
        req_cancel(15'b000_1000_0000_0000);
        check("R7 pending cleared", {31'd0, pending[11]}, 0);
        check("R7 abort set", {31'd0, abort_ack[11]}, 1);
        check("R7 bus untouched", 32'(bus_idx), 3);
        respond(2'd0);
        @(negedge clk); abort_clr = 15'b000_1000_0000_0000;
        @(negedge clk); abort_clr = '0;
        check("R11 abort cleared", {31'd0, abort_ack[11]}, 0);
        clear_flags();
    endtask

    task automatic t_cancel_flight();
        set_id(4, 11'h020);
        req_tx(15'b000_0000_0000_1000);
        wait_bus("R8 mb4 on bus", 4);
        req_cancel(15'b000_0000_0000_1000);
        check("R8 still pending", {31'd0, pending[3]}, 1);
        check("R8 bus kept", {31'd0, bus_req}, 1);
        check("R8 no abort yet", {31'd0, abort_ack[3]}, 0);
        respond(2'd1);
        repeat (5) @(negedge clk);
        check("R8 cancel applied", {31'd0, pending[3]}, 0);
        check("R8 abort set", {31'd0, abort_ack[3]}, 1);
        check("R8 no retry", {31'd0, bus_req}, 0);
        clear_flags();
    endtask

    task automatic t_cancel_success();
        set_id(6, 11'h033);
        req_tx(15'b000_0000_0010_0000);
        wait_bus("R9 mb6 on bus", 6);
        req_cancel(15'b000_0000_0010_0000);
        respond(2'd0);
        repeat (4) @(negedge clk);
        check("R9 ack set", {31'd0, tx_ack[5]}, 1);
        check("R9 abort clear", {31'd0, abort_ack[5]}, 0);
        check("R9 not pending", 32'(pending), 0);
        check("R9 idle", {31'd0, bus_req}, 0);
    endtask

    task automatic t_irq();
        // tx_ack bit 5 is set from t_cancel_success
        @(negedge clk); irq_mask = '0; empty_irq_en = 1'b1; #1;
        check("R10 mask off", {31'd0, irq}, 0);
        @(negedge clk); irq_mask = 15'b000_0000_0010_0000; empty_irq_en = 1'b0; #1;
        check("R10 global off", {31'd0, irq}, 0);
        @(negedge clk); empty_irq_en = 1'b1; #1;
        check("R10 both on", {31'd0, irq}, 1);
        @(negedge clk); irq_mask = 15'b111_1111_1101_1111; #1;
        check("R10 other mask only", {31'd0, irq}, 0);
        @(negedge clk); irq_mask = '1; ack_clr = 15'b000_0000_0010_0000;
        @(negedge clk); ack_clr = '0; #1;
        check("R11 ack cleared", {31'd0, tx_ack[5]}, 0);
        check("R10 R11 irq drops", {31'd0, irq}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_priority();
        t_retry();
        t_cancel_idle();
        t_cancel_flight();
        t_cancel_success();
        t_irq();
        finish_run();
    end
endmodule